// File: doc/BRIEF.md
# Receive-character timeout counter

This block is a down-counter with a ready flag. It serves two uses. In normal mode the host runs it with explicit start and stop strobes. In timeout mode every character the receiver moves into its holding register reloads the counter and restarts it. The flag then rises only when the receive line has been quiet for the programmed number of counting ticks. The ready flag is meant to drive one bit of an interrupt status register. The receiver and the interrupt controller are outside this block.

All inputs are single-cycle strobes or levels sampled on the rising clock edge. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

The counter loads a 16-bit preload value. It decrements once on each cycle in which the tick enable is high. When it reaches zero it stops and raises the ready flag.

Entering timeout mode does three things: it halts the counter, clears the flag and locks out the host start and stop strobes. The counter then waits for the first character before it runs. Leaving timeout mode hands control back to the strobes. It leaves a running count running and leaves a set flag set. A later stop strobe clears the flag.

Top module: `rxto_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ctr_ready`, `ctr_active`, `tmo_active` and `ctr_value` are all 0.
- R2: In normal mode (`tmo_active`=0), a `cmd_start` pulse without `cmd_stop` has the following effect one cycle later: `ctr_value` equals the sampled `preload_val` and `ctr_active`=1. The start strobe leaves `ctr_ready` unchanged.
- R3: While active, the count decreases by one per enabled tick. On the tick that takes it to 0, the counter stops and `ctr_ready` becomes 1. A preload of 0 expires on the first tick. After expiry the counter stays stopped at 0.
- R4: In normal mode, `cmd_stop` halts the counter with its value held and clears `ctr_ready`. When `cmd_start` and `cmd_stop` arrive together, the stop wins and nothing is loaded.
- R5: On a cycle with `tick_en`=0 and no strobes, `ctr_value` is held.
- R6: A `tmo_on` pulse does three things on the next cycle: `tmo_active`=1, `ctr_active`=0 and `ctr_ready`=0. The count value is held. `tmo_on` overrides every other strobe in the same cycle.
- R7: After `tmo_on`, the counter stays stopped until the first `char_done` pulse.
- R8: While `tmo_active`=1, `cmd_start` and `cmd_stop` have no effect on the count, the activity or the flag.
- R9: While `tmo_active`=1, each `char_done` pulse reloads `preload_val` and starts counting. It leaves `ctr_ready` unchanged.
- R10: A `tmo_off` pulse clears `tmo_active`. It does not stop a running count and does not clear `ctr_ready`. After it, start commands work again.
- R11: After timeout mode is left, a `cmd_stop` clears `ctr_ready` and halts the counter.
- R12: In normal mode, `char_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting tick; the count drops by one per high cycle |
| preload_val | input | 16 | Value loaded on start or character restart |
| cmd_start | input | 1 | Host start strobe (normal mode only) |
| cmd_stop | input | 1 | Host stop strobe; also clears the flag (normal mode only) |
| tmo_on | input | 1 | Enter timeout mode |
| tmo_off | input | 1 | Leave timeout mode |
| char_done | input | 1 | Pulse per character moved to the receive holding register |
| ctr_ready | output | 1 | Counter-ready flag |
| ctr_active | output | 1 | Counter is running |
| ctr_value | output | 16 | Current count |
| tmo_active | output | 1 | Timeout mode is on |

## Verification
The bound checker tests the local, one-step rules on every cycle:
- loading on start or on a character in timeout mode;
- expiry at the last tick;
- stop clearing the flag;
- the count holding without a tick;
- entry into timeout mode clearing and halting;
- a halted counter staying halted in timeout mode without a character;
- leaving the mode keeping a set flag.

Only the bench scenarios can show the longer histories. These include a full countdown from the preload to expiry, a restart part-way through a count, and a stop strobe being ignored in timeout mode and honoured once the mode is left. They also cover same-cycle priorities, such as stop over start and mode entry over a start.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_TIMEOUT = 1'b1
  } rxto_mode_e;

  // Actions the decoder asks of the datapath in one cycle
  typedef struct packed {
    logic load;     // copy preload and run
    logic halt;     // stop counting, hold value
    logic clr_rdy;  // drop the ready flag
  } rxto_ctl_t;

endpackage

// File: rtl/rxto_cmd_decode.sv
module rxto_cmd_decode
  import rxto_pkg::*;
(
  input  rxto_mode_e mode_q,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       tmo_on,
  input  logic       tmo_off,
  input  logic       char_done,
  output rxto_ctl_t  ctl,
  output rxto_mode_e mode_nxt
);

  always_comb begin
    ctl      = '0;
    mode_nxt = mode_q;
    if (tmo_on) begin
      // Mode entry overrides every other strobe of the cycle
      mode_nxt    = MODE_TIMEOUT;
      ctl.halt    = 1'b1;
      ctl.clr_rdy = 1'b1;
    end else begin
      if (mode_q == MODE_TIMEOUT) begin
        // Host strobes locked out; only character arrivals rearm
        if (char_done) ctl.load = 1'b1;
      end else begin
        if (cmd_stop) begin
          ctl.halt    = 1'b1;
          ctl.clr_rdy = 1'b1;
        end else if (cmd_start) begin
          ctl.load = 1'b1;
        end
      end
      if (tmo_off) mode_nxt = MODE_NORMAL;
    end
  end

endmodule

// File: rtl/rxto_mode_reg.sv
module rxto_mode_reg
  import rxto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rxto_mode_e mode_nxt,
  output rxto_mode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_nxt;
  end

endmodule

// File: rtl/rxto_downcounter.sv
module rxto_downcounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic last_step;
  assign last_step = (cnt_q == '0) || (cnt_q == CNT_ONE);
  assign expire    = run_q && tick_en && !load && !halt && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (run_q && tick_en) begin
      cnt_q <= (cnt_q == '0) ? '0 : cnt_q - CNT_ONE;
      if (last_step) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rxto_ready_flag.sv
module rxto_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

endmodule

// File: rtl/rxto_timer.sv
module rxto_timer
  import rxto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] preload_val,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             tmo_on,
  input  logic             tmo_off,
  input  logic             char_done,
  output logic             ctr_ready,
  output logic             ctr_active,
  output logic [CNT_W-1:0] ctr_value,
  output logic             tmo_active
);

  rxto_mode_e mode_q;
  rxto_mode_e mode_nxt;
  rxto_ctl_t  ctl;
  logic       expire;

  rxto_cmd_decode u_dec (
    .mode_q    (mode_q),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .tmo_on    (tmo_on),
    .tmo_off   (tmo_off),
    .char_done (char_done),
    .ctl       (ctl),
    .mode_nxt  (mode_nxt)
  );

  rxto_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_nxt (mode_nxt),
    .mode_q   (mode_q)
  );

  rxto_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl.load),
    .halt     (ctl.halt),
    .tick_en  (tick_en),
    .load_val (preload_val),
    .cnt_q    (ctr_value),
    .run_q    (ctr_active),
    .expire   (expire)
  );

  rxto_ready_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (expire),
    .clr_i  (ctl.clr_rdy),
    .flag_q (ctr_ready)
  );

  assign tmo_active = (mode_q == MODE_TIMEOUT);

endmodule

// File: rtl/rxto_timer_chk.sv
module rxto_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [CNT_W-1:0] preload_val,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             tmo_on,
  input logic             tmo_off,
  input logic             char_done,
  input logic             ctr_ready,
  input logic             ctr_active,
  input logic [CNT_W-1:0] ctr_value,
  input logic             tmo_active
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic any_strobe;
  assign any_strobe = cmd_start || cmd_stop || tmo_on || char_done;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ctr_ready && !ctr_active && !tmo_active));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_active && cmd_start && !cmd_stop && !tmo_on)
      |=> (ctr_active && ctr_value == $past(preload_val)));

  assert_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_active && tick_en && !any_strobe && ctr_value <= ONE)
      |=> (ctr_ready && !ctr_active && ctr_value == '0));

  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_active && cmd_stop && !tmo_on) |=> (!ctr_ready && !ctr_active));

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !any_strobe) |=> $stable(ctr_value));

  assert_tmo_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_on |=> (tmo_active && !ctr_ready && !ctr_active));

  assert_wait_first_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_active && !ctr_active && !tmo_on && !char_done) |=> !ctr_active);

  assert_char_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_active && char_done && !tmo_on)
      |=> (ctr_active && ctr_value == $past(preload_val)));

  assert_exit_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_active && tmo_off && !tmo_on && ctr_ready) |=> (!tmo_active && ctr_ready));

endmodule

bind rxto_timer rxto_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .preload_val (preload_val),
  .cmd_start   (cmd_start),
  .cmd_stop    (cmd_stop),
  .tmo_on      (tmo_on),
  .tmo_off     (tmo_off),
  .char_done   (char_done),
  .ctr_ready   (ctr_ready),
  .ctr_active  (ctr_active),
  .ctr_value   (ctr_value),
  .tmo_active  (tmo_active)
);

// File: tb/tb_rxto_timer.sv
module tb_rxto_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic [W-1:0] preload_val = '0;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, tmo_on = 1'b0, tmo_off = 1'b0, char_done = 1'b0;
  logic ctr_ready, ctr_active, tmo_active;
  logic [W-1:0] ctr_value;

  rxto_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .preload_val(preload_val),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .tmo_on(tmo_on),
    .tmo_off(tmo_off), .char_done(char_done), .ctr_ready(ctr_ready),
    .ctr_active(ctr_active), .ctr_value(ctr_value), .tmo_active(tmo_active)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic        rdy;
    logic        act;
    logic        mode;
    logic [W-1:0] cnt;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int base = 0;
  bit done = 1'b0;

  task automatic expect_at(input int due, input logic r, input logic a,
                           input logic m, input logic [W-1:0] c, input string req);
    exp_t e;
    e.due = due; e.rdy = r; e.act = a; e.mode = m; e.cnt = c; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: samples a quarter period after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #5;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (e.due != cyc) begin
        n_fail++;
        $display("FAIL %s: check missed, actual cycle=%0d expected cycle=%0d", e.req, cyc, e.due);
      end else if (ctr_ready !== e.rdy || ctr_active !== e.act ||
                   tmo_active !== e.mode || ctr_value !== e.cnt) begin
        n_fail++;
        $display("FAIL %s @%0d: actual rdy=%b act=%b mode=%b cnt=%0d expected rdy=%b act=%b mode=%b cnt=%0d",
                 e.req, cyc, ctr_ready, ctr_active, tmo_active, ctr_value,
                 e.rdy, e.act, e.mode, e.cnt);
      end
    end
  end

  task automatic cmd(input bit st, input bit sp, input bit on, input bit off, input bit ch);
    @(negedge clk);
    base = cyc;
    cmd_start = st; cmd_stop = sp; tmo_on = on; tmo_off = off; char_done = ch;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_start = 1'b0; cmd_stop = 1'b0; tmo_on = 1'b0; tmo_off = 1'b0; char_done = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int b1, b2, b3, b4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_at(cyc + 1, 0, 0, 0, 0, "R1");
    idle(2);

    // Normal mode: full countdown from 5
    preload_val = 5;
    cmd(1, 0, 0, 0, 0);
    expect_at(base + 1, 0, 1, 0, 5, "R2");
    expect_at(base + 5, 0, 1, 0, 1, "R3");
    expect_at(base + 6, 1, 0, 0, 0, "R3");
    expect_at(base + 9, 1, 0, 0, 0, "R3");
    idle(10);

    // Character strobe ignored in normal mode
    cmd(0, 0, 0, 0, 1);
    expect_at(base + 1, 1, 0, 0, 0, "R12");
    idle(2);

    // Stop clears the flag
    cmd(0, 1, 0, 0, 0);
    expect_at(base + 1, 0, 0, 0, 0, "R4");
    idle(2);

    // Stop mid-count holds the value
    preload_val = 8;
    cmd(1, 0, 0, 0, 0); b1 = base;
    expect_at(b1 + 1, 0, 1, 0, 8, "R2");
    idle(3);
    cmd(0, 1, 0, 0, 0); b2 = base;
    expect_at(b2 + 1, 0, 0, 0, W'(9 - (b2 - b1)), "R4");
    expect_at(b2 + 4, 0, 0, 0, W'(9 - (b2 - b1)), "R4");
    idle(5);

    // Start and stop together: stop wins, nothing loaded
    cmd(1, 1, 0, 0, 0);
    expect_at(base + 1, 0, 0, 0, W'(9 - (b2 - b1)), "R4");
    idle(2);

    // No tick: count held
    tick_en = 1'b0;
    preload_val = 3;
    cmd(1, 0, 0, 0, 0);
    expect_at(base + 1, 0, 1, 0, 3, "R2");
    expect_at(base + 3, 0, 1, 0, 3, "R5");
    idle(3);
    tick_en = 1'b1;
    expect_at(base + 4, 0, 1, 0, 2, "R5");
    expect_at(base + 6, 1, 0, 0, 0, "R3");
    idle(5);

    // Preload zero expires on the first tick
    cmd(0, 1, 0, 0, 0);
    expect_at(base + 1, 0, 0, 0, 0, "R4");
    idle(2);
    preload_val = 0;
    cmd(1, 0, 0, 0, 0);
    expect_at(base + 1, 0, 1, 0, 0, "R3");
    expect_at(base + 2, 1, 0, 0, 0, "R3");
    idle(3);

    // Enter timeout mode while running with flag set
    preload_val = 20;
    cmd(1, 0, 0, 0, 0); b1 = base;
    expect_at(b1 + 1, 1, 1, 0, 20, "R2");
    idle(2);
    cmd(0, 0, 1, 0, 0); b2 = base;
    expect_at(b2 + 1, 0, 0, 1, W'(21 - (b2 - b1)), "R6");
    expect_at(b2 + 5, 0, 0, 1, W'(21 - (b2 - b1)), "R7");
    idle(5);

    // Start ignored in timeout mode
    cmd(1, 0, 0, 0, 0);
    expect_at(base + 1, 0, 0, 1, W'(21 - (b2 - b1)), "R8");
    idle(2);

    // First character starts the count; expiry in timeout mode
    preload_val = 4;
    cmd(0, 0, 0, 0, 1);
    expect_at(base + 1, 0, 1, 1, 4, "R9");
    expect_at(base + 4, 0, 1, 1, 1, "R9");
    expect_at(base + 5, 1, 0, 1, 0, "R3");
    idle(6);

    // Restart mid-count, flag untouched
    preload_val = 6;
    cmd(0, 0, 0, 0, 1); b1 = base;
    expect_at(b1 + 1, 1, 1, 1, 6, "R9");
    idle(2);
    cmd(0, 0, 0, 0, 1); b2 = base;
    expect_at(b2 + 1, 1, 1, 1, 6, "R9");
    idle(1);
    cmd(0, 1, 0, 0, 0); b3 = base;
    expect_at(b3 + 1, 1, 1, 1, W'(6 - (b3 - b2)), "R8");
    idle(1);

    // Leave timeout mode: keeps running and flag
    cmd(0, 0, 0, 1, 0); b4 = base;
    expect_at(b4 + 1, 1, 1, 0, W'(6 - (b4 - b2)), "R10");
    idle(1);
    cmd(0, 1, 0, 0, 0);
    expect_at(base + 1, 0, 0, 0, W'(6 - (base - b2 - 1)), "R11");
    idle(2);

    // Start works again after leaving the mode
    preload_val = 2;
    cmd(1, 0, 0, 0, 0);
    expect_at(base + 1, 0, 1, 0, 2, "R10");
    expect_at(base + 2, 0, 1, 0, 1, "R10");
    expect_at(base + 3, 1, 0, 0, 0, "R3");
    idle(4);

    // Mode entry overrides a start in the same cycle
    cmd(1, 0, 1, 0, 0);
    expect_at(base + 1, 0, 0, 1, 0, "R6");
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule